// File: doc/BRIEF.md
# Serial-Bus DAC Control Register Slave

This block is a two-wire serial slave that sits between a host-side clock/data bus and the control inputs of a pair of tuning DACs and their boost supply. It oversamples the bus clock and data line in the system clock domain and spots the sequence start pulse. It then decodes a command frame carrying a 4-bit slave identifier, and either takes in a multi-byte extended register write or answers a plain register read of its status byte. Every frame ends in an odd parity bit. A bad parity bit aborts the sequence and sets a sticky error flag.

Incoming bytes are held in shadow registers and applied together once the closing bus park cycle arrives. A multi-register load, such as the three-byte DAC load at start address 0x01 (a trim byte, then the DAC A code, then the DAC B code), therefore reaches the outputs in a single system clock cycle. The register values themselves are the block's outputs. The only bus output is the read data with its drive enable.

Sequencer states: IDLE waits for a start pulse. CMD shifts in the 13-bit command frame. ADDR takes the starting address. WDATA takes data bytes. WPARK waits for the park cycle and commits. RTURN is the turnaround park before read data. RDATA drives the status frame. IGNORE waits for the next start pulse. Transitions: a start pulse from any state goes to CMD. CMD goes to ADDR on a good extended write, to RTURN on a good status read, and to IGNORE otherwise. ADDR goes to WDATA, or to IGNORE on bad parity. WDATA loops while bytes remain, then goes to WPARK, or to IGNORE on bad parity. WPARK goes to IDLE with a commit. RTURN goes to RDATA. RDATA goes to IDLE after nine bits.

Top module: `rffe_dac_slave`

## Requirements
- R1: After reset the outputs read: configuration 0x40, trim 0x00, DAC A 0x00, DAC B 0x00, boost 0x1B, error flag 0, drive enable 0.
- R2: A sequence begins only with a start pulse: sdata_in rises and then falls while sclk is low. Bits are captured on sclk falling edges, MSB first. A command frame is the 4-bit slave identifier, an 8-bit command, then parity. Frames clocked without a start pulse change nothing.
- R3: Command 0000nnnn is an extended write of nnnn+1 bytes. It is followed by an 8-bit starting address frame and then the data frames. Bytes land at consecutive addresses: 0x00 configuration, 0x01 trim, 0x02 DAC A, 0x03 DAC B, 0x10 boost. Bytes sent to any other address are dropped.
- R4: Written values appear at the outputs only after the bus park cycle that follows the last data frame. All registers written by one sequence change in the same system clock cycle.
- R5: Each frame carries odd parity: the data bits and the parity bit together hold an odd number of ones. A parity failure in the command, address or data frame of an addressed sequence discards every byte of that sequence and sets the error flag, which stays set.
- R6: A sequence whose slave identifier differs from SLV_ID (default 4'h7) writes nothing and never drives the data line.
- R7: In the configuration register, only bit 6 (spread-spectrum enable), bit 3 (DAC A enable) and bit 2 (DAC B enable) take written values. All other bits read 0.
- R8: In the boost register, bits 7:5 read 0 and bit 4 reads 1. Bits 3:0 hold the written voltage-step field.
- R9: Command 011aaaaa with aaaaa = 0x1A is a status read. After one turnaround park cycle the block drives nine bits MSB first, {7'b0, error flag, odd parity}, each valid around the sclk high phase. The error flag clears when the read completes.
- R10: Extended reads (command 0010nnnn) and plain reads of any address other than 0x1A never assert sdata_oe.
- R11: DAC A and DAC B keep the low 7 bits of a written byte. Bit 7 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Bus clock, asynchronous |
| sdata_in | input | 1 | Bus data from the master, asynchronous |
| sdata_out | output | 1 | Read data driven onto the bus |
| sdata_oe | output | 1 | Drive enable for sdata_out |
| cfg_o | output | 8 | Configuration register (enable mask) |
| tc_o | output | 8 | Trim byte |
| dac_a_o | output | 7 | DAC A code |
| dac_b_o | output | 7 | DAC B code |
| boost_o | output | 8 | Boost mode register |
| err_o | output | 1 | Sticky parity error flag |

## Verification
A wrong bit counter or a wrong sequencer state shows up within one sequence. The write would miss the register outputs after park, land at the wrong address, or come out as a read that drives the line at the wrong time. A shadow or pending bit left over from an aborted sequence only shows after the next committed write, as an extra register change at park. So every error case is followed by a clean write and a full output comparison. Commit skew between the two DAC codes is visible only at system-clock resolution, so the cycle of each output change is recorded and compared.

// File: rtl/rffe_dac_pkg.sv
package rffe_dac_pkg;

    localparam int CMD_BITS = 13;
    localparam int FRM_BITS = 9;
    localparam int NREG     = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_ADDR, ST_WDATA, ST_WPARK, ST_RTURN, ST_RDATA, ST_IGNORE
    } seq_state_e;

    function automatic logic [7:0] reg_addr(input int idx);
        case (idx)
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'h02;
            3: return 8'h03;
            default: return 8'h10;
        endcase
    endfunction

    function automatic logic [7:0] reg_mask(input int idx);
        case (idx)
            0: return 8'h4C;
            1: return 8'hFF;
            2: return 8'h7F;
            3: return 8'h7F;
            default: return 8'h0F;
        endcase
    endfunction

    function automatic logic [7:0] reg_force(input int idx);
        return (idx == 4) ? 8'h10 : 8'h00;
    endfunction

    function automatic logic [7:0] reg_reset(input int idx);
        case (idx)
            0: return 8'h40;
            4: return 8'h1B;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/rffe_bus_sync.sv
module rffe_bus_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] pipe_q [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
            prev_q <= '0;
        end else begin
            pipe_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            prev_q <= pipe_q[STAGES-1];
        end
    end

    assign level_o = pipe_q[STAGES-1];
    assign rise_o  = pipe_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~pipe_q[STAGES-1] & prev_q;
endmodule

// File: rtl/rffe_seq_fsm.sv
module rffe_seq_fsm
    import rffe_dac_pkg::*;
#(
    parameter logic [3:0] SLV_ID      = 4'h7,
    parameter logic [4:0] STATUS_ADDR = 5'h1A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_lvl_i,
    input  logic       sck_rise_i,
    input  logic       sck_fall_i,
    input  logic       sd_lvl_i,
    input  logic       sd_rise_i,
    input  logic       sd_fall_i,
    input  logic [7:0] status_i,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic       commit_o,
    output logic       discard_o,
    output logic       set_err_o,
    output logic       clr_err_o,
    output logic       sdata_out_o,
    output logic       sdata_oe_o
);
    seq_state_e state_q, state_d;
    logic        armed_q, ssc;
    logic [11:0] sr_q;
    logic [12:0] nsr;
    logic [3:0]  cnt_q, ncnt, flen, left_q;
    logic [7:0]  addr_q;
    logic [8:0]  osr_q;
    logic        frame_done, cmd_par_ok, dat_par_ok, id_hit, is_ewr, is_rd, par_fail;

    assign ssc        = armed_q && sd_fall_i && !sck_lvl_i;
    assign nsr        = {sr_q, sd_lvl_i};
    assign ncnt       = cnt_q + 4'd1;
    assign flen       = (state_q == ST_CMD) ? 4'(CMD_BITS) : 4'(FRM_BITS);
    assign frame_done = sck_fall_i && (ncnt == flen);
    assign cmd_par_ok = ^nsr;
    assign dat_par_ok = ^nsr[8:0];
    assign id_hit     = (nsr[12:9] == SLV_ID);
    assign is_ewr     = (nsr[8:5] == 4'h0);
    assign is_rd      = (nsr[8:6] == 3'b011) && (nsr[5:1] == STATUS_ADDR);

    // start-pulse arming: data rise with clock low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        armed_q <= 1'b0;
        else if (sd_rise_i && !sck_lvl_i)  armed_q <= 1'b1;
        else if (sck_rise_i || ssc)        armed_q <= 1'b0;
    end

    always_comb begin
        state_d = state_q;
        if (ssc) begin
            state_d = ST_CMD;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_CMD: if (frame_done) begin
                    if (!id_hit || !cmd_par_ok) state_d = ST_IGNORE;
                    else if (is_ewr)            state_d = ST_ADDR;
                    else if (is_rd)             state_d = ST_RTURN;
                    else                        state_d = ST_IGNORE;
                end
                ST_ADDR:  if (frame_done) state_d = dat_par_ok ? ST_WDATA : ST_IGNORE;
                ST_WDATA: if (frame_done) begin
                    if (!dat_par_ok)          state_d = ST_IGNORE;
                    else if (left_q == 4'd0)  state_d = ST_WPARK;
                end
                ST_WPARK: if (sck_fall_i) state_d = ST_IDLE;
                ST_RTURN: if (sck_fall_i) state_d = ST_RDATA;
                ST_RDATA: if (sck_fall_i && ncnt == 4'(FRM_BITS)) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        par_fail    = frame_done &&
                      (((state_q == ST_CMD) && id_hit && !cmd_par_ok) ||
                       (((state_q == ST_ADDR) || (state_q == ST_WDATA)) && !dat_par_ok));
        wr_en_o     = (state_q == ST_WDATA) && frame_done && dat_par_ok && !ssc;
        wr_addr_o   = addr_q;
        wr_data_o   = nsr[8:1];
        commit_o    = (state_q == ST_WPARK) && sck_fall_i && !ssc;
        set_err_o   = par_fail && !ssc;
        discard_o   = ssc || par_fail;
        clr_err_o   = (state_q == ST_RDATA) && sck_fall_i && (ncnt == 4'(FRM_BITS)) && !ssc;
        sdata_oe_o  = (state_q == ST_RDATA);
        sdata_out_o = osr_q[8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0; cnt_q <= '0; left_q <= '0; addr_q <= '0; osr_q <= '0;
        end else if (ssc) begin
            sr_q <= '0; cnt_q <= '0;
        end else if (sck_fall_i) begin
            unique case (state_q)
                ST_CMD, ST_ADDR, ST_WDATA: begin
                    sr_q  <= nsr[11:0];
                    cnt_q <= frame_done ? 4'd0 : ncnt;
                    if (frame_done && state_q == ST_CMD)  left_q <= nsr[4:1];
                    if (frame_done && state_q == ST_ADDR) addr_q <= nsr[8:1];
                    if (frame_done && state_q == ST_WDATA) begin
                        addr_q <= addr_q + 8'd1;
                        left_q <= left_q - 4'd1;
                    end
                end
                ST_RTURN: begin
                    osr_q <= {status_i, ~^status_i};
                    cnt_q <= 4'd0;
                end
                ST_RDATA: begin
                    osr_q <= {osr_q[7:0], 1'b0};
                    cnt_q <= (ncnt == 4'(FRM_BITS)) ? 4'd0 : ncnt;
                end
                default: ;
            endcase
        end
    end

    assert_start_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ssc |=> (state_q == ST_CMD));
    assert_oe_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe_o) |-> $past(sck_fall_i));
endmodule

// File: rtl/rffe_regfile.sv
module rffe_regfile
    import rffe_dac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [7:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic       commit_i,
    input  logic       discard_i,
    input  logic       set_err_i,
    input  logic       clr_err_i,
    output logic [7:0] cfg_o,
    output logic [7:0] tc_o,
    output logic [6:0] dac_a_o,
    output logic [6:0] dac_b_o,
    output logic [7:0] boost_o,
    output logic       err_o,
    output logic [7:0] status_o
);
    logic [7:0] live_q [NREG];
    logic [7:0] shadow_q [NREG];
    logic       pend_q [NREG];
    logic       err_q;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q[g] <= '0;
                pend_q[g]   <= 1'b0;
                live_q[g]   <= reg_reset(g);
            end else begin
                if (commit_i || discard_i) pend_q[g] <= 1'b0;
                else if (wr_en_i && wr_addr_i == reg_addr(g)) begin
                    shadow_q[g] <= wr_data_i;
                    pend_q[g]   <= 1'b1;
                end
                if (commit_i && pend_q[g])
                    live_q[g] <= (shadow_q[g] & reg_mask(g)) | reg_force(g);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         err_q <= 1'b0;
        else if (set_err_i) err_q <= 1'b1;
        else if (clr_err_i) err_q <= 1'b0;
    end

    assign cfg_o    = live_q[0];
    assign tc_o     = live_q[1];
    assign dac_a_o  = live_q[2][6:0];
    assign dac_b_o  = live_q[3][6:0];
    assign boost_o  = live_q[4];
    assign err_o    = err_q;
    assign status_o = {7'b0, err_q};

    assert_dac_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(live_q[2]) || !$stable(live_q[3])) |-> $past(commit_i));
    assert_cfg_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(live_q[0]) || !$stable(live_q[4])) |-> $past(commit_i));
    assert_err_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(set_err_i));
    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_q) |-> $past(clr_err_i));
endmodule

// File: rtl/rffe_dac_slave.sv
module rffe_dac_slave #(
    parameter logic [3:0] SLV_ID      = 4'h7,
    parameter logic [4:0] STATUS_ADDR = 5'h1A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       sdata_in,
    output logic       sdata_out,
    output logic       sdata_oe,
    output logic [7:0] cfg_o,
    output logic [7:0] tc_o,
    output logic [6:0] dac_a_o,
    output logic [6:0] dac_b_o,
    output logic [7:0] boost_o,
    output logic       err_o
);
    logic [1:0] lvl, rise, fall;
    logic       wr_en, commit, discard, set_err, clr_err;
    logic [7:0] wr_addr, wr_data, status;

    rffe_bus_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i({sdata_in, sclk}),
        .level_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    rffe_seq_fsm #(.SLV_ID(SLV_ID), .STATUS_ADDR(STATUS_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sck_lvl_i(lvl[0]), .sck_rise_i(rise[0]), .sck_fall_i(fall[0]),
        .sd_lvl_i(lvl[1]), .sd_rise_i(rise[1]), .sd_fall_i(fall[1]),
        .status_i(status),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .commit_o(commit), .discard_o(discard), .set_err_o(set_err), .clr_err_o(clr_err),
        .sdata_out_o(sdata_out), .sdata_oe_o(sdata_oe)
    );

    rffe_regfile u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .commit_i(commit), .discard_i(discard), .set_err_i(set_err), .clr_err_i(clr_err),
        .cfg_o(cfg_o), .tc_o(tc_o), .dac_a_o(dac_a_o), .dac_b_o(dac_b_o),
        .boost_o(boost_o), .err_o(err_o), .status_o(status)
    );
endmodule

// File: tb/rffe_dac_slave_bench.sv
module rffe_dac_slave_bench;
    localparam logic [3:0] SA    = 4'h7;
    localparam logic [3:0] OTHER = 4'h3;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdata = 1'b0;
    logic sdata_out, sdata_oe, err_o;
    logic [7:0] cfg_o, tc_o, boost_o;
    logic [6:0] dac_a_o, dac_b_o;

    always #2 clk = ~clk;

    rffe_dac_slave u_rffe_dac_slave (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata_in(sdata),
        .sdata_out(sdata_out), .sdata_oe(sdata_oe),
        .cfg_o(cfg_o), .tc_o(tc_o), .dac_a_o(dac_a_o), .dac_b_o(dac_b_o),
        .boost_o(boost_o), .err_o(err_o)
    );

    typedef struct {
        string      tag;
        logic [7:0] cfg, tc, boost;
        logic [6:0] a, b;
        logic       err;
    } exp_t;

    exp_t exp_q[$];
    event mon_ev;
    int   total = 0, fails = 0;
    logic [7:0] m_cfg = 8'h40, m_tc = 8'h00, m_boost = 8'h1B;
    logic [6:0] m_a = '0, m_b = '0;
    logic       m_err = 1'b0;

    int cyc = 0, ta = 0, tb = 0, oe_cnt = 0;
    logic [6:0] prev_a = '0, prev_b = '0;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (dac_a_o !== prev_a) ta = cyc;
        if (dac_b_o !== prev_b) tb = cyc;
        prev_a = dac_a_o;
        prev_b = dac_b_o;
        if (sdata_oe) oe_cnt = oe_cnt + 1;
    end

    task automatic chk(input string tag, input string fld, input int act, input int expv);
        total++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, fld, act, expv);
        end
    endtask

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            exp_t it;
            @(mon_ev);
            it = exp_q.pop_front();
            chk(it.tag, "cfg",   int'(cfg_o),   int'(it.cfg));
            chk(it.tag, "tc",    int'(tc_o),    int'(it.tc));
            chk(it.tag, "dac_a", int'(dac_a_o), int'(it.a));
            chk(it.tag, "dac_b", int'(dac_b_o), int'(it.b));
            chk(it.tag, "boost", int'(boost_o), int'(it.boost));
            chk(it.tag, "err",   int'(err_o),   int'(it.err));
        end
    end

    task automatic snap(input string tag);
        exp_t it;
        it.tag = tag; it.cfg = m_cfg; it.tc = m_tc; it.boost = m_boost;
        it.a = m_a; it.b = m_b; it.err = m_err;
        exp_q.push_back(it);
        repeat (3) @(negedge clk);
        ->mon_ev;
        @(negedge clk);
    endtask

    task automatic bus_bit(input logic b);
        @(negedge clk) sclk = 1'b1;
        @(negedge clk) sdata = b;
        repeat (7) @(negedge clk);
        sclk = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic start_pulse();
        @(negedge clk) sdata = 1'b1;
        repeat (8) @(negedge clk);
        sdata = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_bits(input logic [12:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) bus_bit(v[i]);
    endtask

    task automatic send_cmd(input logic [3:0] sa, input logic [7:0] c, input logic flip);
        send_bits({sa, c, (~^{sa, c}) ^ flip}, 13);
    endtask

    task automatic send_byte(input logic [7:0] d, input logic flip);
        send_bits({4'h0, d, (~^d) ^ flip}, 9);
    endtask

    // bad: -1 none, 0 command, 1 address, 2+ data frame index
    task automatic ext_write(input logic [3:0] sa, input logic [7:0] start, input int n,
                             input logic [23:0] d, input int bad, input bit park);
        start_pulse();
        send_cmd(sa, {4'h0, 4'(n - 1)}, bad == 0);
        send_byte(start, bad == 1);
        for (int i = 0; i < n; i++) send_byte(d[23 - 8*i -: 8], bad == i + 2);
        if (park) bus_bit(1'b0);
    endtask

    task automatic read_reg(input logic [3:0] sa, input logic [4:0] a,
                            output logic [8:0] got, output bit oe_all);
        start_pulse();
        send_cmd(sa, {3'b011, a}, 1'b0);
        bus_bit(1'b0);
        oe_all = 1'b1;
        got = '0;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk) sclk = 1'b1;
            sdata = 1'b0;
            repeat (7) @(negedge clk);
            got = {got[7:0], sdata_out};
            if (!sdata_oe) oe_all = 1'b0;
            sclk = 1'b0;
            repeat (8) @(negedge clk);
        end
        bus_bit(1'b0);
    endtask

    initial begin
        logic [8:0] got;
        bit         oe_all;
        int         oe_before;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 reset", "oe", int'(sdata_oe), 0);
        snap("R1 reset");

        // staged DAC load: nothing moves before park, both codes move together
        ext_write(SA, 8'h01, 3, {8'hA5, 8'h55, 8'h2A}, -1, 1'b0);
        snap("R4 before park");
        bus_bit(1'b0);
        m_tc = 8'hA5; m_a = 7'h55; m_b = 7'h2A;
        snap("R3 dac load");
        chk("R4 same cycle", "ta-tb", ta - tb, 0);

        ext_write(SA, 8'h02, 2, {8'hFF, 8'h80, 8'h00}, -1, 1'b1);
        m_a = 7'h7F; m_b = 7'h00;
        snap("R11 dac width");

        ext_write(SA, 8'h00, 1, {8'hFF, 16'h0}, -1, 1'b1);
        m_cfg = 8'h4C;
        snap("R7 cfg mask ones");
        ext_write(SA, 8'h00, 1, {8'h00, 16'h0}, -1, 1'b1);
        m_cfg = 8'h00;
        snap("R7 cfg mask zeros");

        ext_write(SA, 8'h10, 1, {8'hE3, 16'h0}, -1, 1'b1);
        m_boost = 8'h13;
        snap("R8 boost reserved");
        ext_write(SA, 8'h10, 1, {8'h00, 16'h0}, -1, 1'b1);
        m_boost = 8'h10;
        snap("R8 boost fixed bit");

        ext_write(SA, 8'h03, 2, {8'h11, 8'h22, 8'h00}, -1, 1'b1);
        m_b = 7'h11;
        snap("R3 unmapped skipped");

        oe_before = oe_cnt;
        ext_write(OTHER, 8'h02, 1, {8'h01, 16'h0}, -1, 1'b1);
        snap("R6 other id write");
        read_reg(OTHER, 5'h1A, got, oe_all);
        chk("R6 other id read", "oe cycles", oe_cnt - oe_before, 0);

        // full write frames with no start pulse
        send_cmd(SA, 8'h00, 1'b0);
        send_byte(8'h02, 1'b0);
        send_byte(8'h33, 1'b0);
        bus_bit(1'b0);
        snap("R2 no start pulse");

        ext_write(SA, 8'h01, 3, {8'h01, 8'h02, 8'h03}, 3, 1'b1);
        m_err = 1'b1;
        snap("R5 data parity");

        read_reg(SA, 5'h1A, got, oe_all);
        chk("R9 status err", "frame", int'(got), 9'h002);
        chk("R9 status err", "oe", int'(oe_all), 1);
        m_err = 1'b0;
        snap("R9 err cleared");
        read_reg(SA, 5'h1A, got, oe_all);
        chk("R9 status clean", "frame", int'(got), 9'h001);

        ext_write(SA, 8'h02, 1, {8'h44, 16'h0}, 0, 1'b1);
        m_err = 1'b1;
        snap("R5 command parity");
        read_reg(SA, 5'h1A, got, oe_all);
        chk("R9 status after cmd parity", "frame", int'(got), 9'h002);
        ext_write(SA, 8'h02, 1, {8'h44, 16'h0}, 1, 1'b1);
        snap("R5 address parity");
        read_reg(SA, 5'h1A, got, oe_all);
        m_err = 1'b0;

        oe_before = oe_cnt;
        start_pulse();
        send_cmd(SA, 8'h20, 1'b0);
        send_byte(8'h02, 1'b0);
        for (int i = 0; i < 11; i++) bus_bit(1'b0);
        chk("R10 extended read", "oe cycles", oe_cnt - oe_before, 0);
        read_reg(SA, 5'h05, got, oe_all);
        chk("R10 other read addr", "oe cycles", oe_cnt - oe_before, 0);

        ext_write(SA, 8'h01, 1, {8'h3C, 16'h0}, -1, 1'b1);
        m_tc = 8'h3C;
        snap("R2 recovery write");

        repeat (10) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule